// File: doc/BRIEF.md
# Reversible Shift-Register Up/Down Counter

This block counts with a 15-bit maximal-length linear feedback shift register instead of a binary adder. Each enabled cycle moves the register one state forward or one state back along its fixed pseudo-random sequence. Forward steps need a single XOR in the feedback path. A backward step shifts the other way and puts a single XOR on the opposite end, so it exactly undoes one forward step. The state values do not follow numeric order. The design relies only on two properties: every step can be undone exactly, and two states can be compared for equality.

A timer built on this block works as follows. Software precomputes the register state that lies N forward steps past the restart seed, and loads it as the target. The load also returns the register to the seed. The match output then goes high after exactly N net forward steps. Steps taken in the reverse direction lengthen the interval, one state per step. The all-zero state would lock up the feedback, so the block never enters it.

Top module: `lfsr_updown_counter`

## Requirements
- R1: While rstN is low and on the first cycle after it rises, state equals the seed 15'h0001, the target equals the seed, and atTarget is 1.
- R2: A forward step (stepEn=1, stepDown=0, loadStrobe=0) changes state q to {q[13:0], q[14]^q[13]} at the next rising clock edge: every bit moves up one place and bit 0 receives the XOR of bits 14 and 13.
- R3: A reverse step (stepEn=1, stepDown=1, loadStrobe=0) changes q to {q[0]^q[14], q[14:1]}: every bit moves down one place and bit 14 receives the XOR of bits 0 and 14. Any run of forward steps followed by the same number of reverse steps returns the starting state.
- R4: With stepEn=0 and loadStrobe=0, state does not change.
- R5: Starting from the seed, 32767 consecutive forward steps visit 32767 distinct states and come back to the seed only on the last step.
- R6: state is never all zeros.
- R7: When loadStrobe=1 at a rising edge, the target takes loadValue and state returns to the seed at that edge. This holds whatever stepEn and stepDown are at that edge: a load takes priority over a step.
- R8: When the loaded value is zero, the seed 15'h0001 is stored as the target instead.
- R9: atTarget is 1 exactly when state equals the stored target. It is combinational and responds in the same cycle as the state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| stepEn | input | 1 | Take one step this cycle |
| stepDown | input | 1 | Step direction: 0 forward, 1 reverse |
| loadStrobe | input | 1 | Store a new target and restart at the seed |
| loadValue | input | 15 | Target state to store |
| state | output | 15 | Current register state |
| atTarget | output | 1 | State equals the stored target |

## Verification
The bench walks the entire forward sequence from the seed. A feedback tap in the wrong place would produce a short cycle that returns to the seed too early, or would reach zero and stick there. Random walks that go forward and then back by the same count find a reverse feedback that is not the exact inverse, because the walk ends away from its starting state. Directed cases cover a load on the same edge as a step, a load of zero, and reaching the target from either direction. A design that gave a step priority over a load, stored zero as the target, or registered the match flag would show the wrong state or flag on those cycles.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

  localparam int unsigned DefaultWidth = 15;

  // Strobes from the control decode to the datapath; at most one is high.
  typedef struct packed {
    logic stepFwd;
    logic stepRev;
    logic loadTarget;
  } lfsrStrobes_t;

endpackage

// File: rtl/lfsr_ctrl.sv
module lfsr_ctrl
  import lfsr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         stepEn,
  input  logic         stepDown,
  input  logic         loadStrobe,
  output lfsrStrobes_t strobes
);

  // A load wins over a step taken on the same edge.
  always_comb begin
    strobes            = '0;
    strobes.loadTarget = loadStrobe;
    strobes.stepFwd    = !loadStrobe && stepEn && !stepDown;
    strobes.stepRev    = !loadStrobe && stepEn &&  stepDown;
  end

  // R7: mutual exclusion between load and the two step directions
  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.stepFwd, strobes.stepRev, strobes.loadTarget}));

  // R7: a requested load is never dropped in favour of a step
  a_r7_load_priority: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |-> (strobes.loadTarget && !strobes.stepFwd && !strobes.stepRev));

endmodule

// File: rtl/lfsr_datapath.sv
module lfsr_datapath
  import lfsr_pkg::*;
#(
  parameter int unsigned WIDTH   = DefaultWidth,
  parameter int unsigned TAP_IDX = DefaultWidth - 2,
  parameter logic [WIDTH-1:0] SEED = {{(WIDTH-1){1'b0}}, 1'b1}
) (
  input  logic             clk,
  input  logic             rstN,
  input  lfsrStrobes_t     strobes,
  input  logic [WIDTH-1:0] loadValue,
  output logic [WIDTH-1:0] state,
  output logic             atTarget
);

  localparam int unsigned TopIdx = WIDTH - 1;

  logic [WIDTH-1:0] stateQ;
  logic [WIDTH-1:0] targetQ;
  logic [WIDTH-1:0] fwdNext;
  logic [WIDTH-1:0] revNext;
  logic [WIDTH-1:0] targetIn;

  // Forward step: shift up, bit 0 receives the XOR of the top bit and the tap bit.
  assign fwdNext = {stateQ[TopIdx-1:0], stateQ[TopIdx] ^ stateQ[TAP_IDX]};
  // Reverse step: shift down, recovering the old top bit from the bit that was
  // just shifted in and the moved tap bit.
  assign revNext = {stateQ[0] ^ stateQ[TAP_IDX+1], stateQ[TopIdx:1]};

  // Zero would lock up the feedback, so it is replaced by the seed.
  assign targetIn = (loadValue == '0) ? SEED : loadValue;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= SEED;
      targetQ <= SEED;
    end else if (strobes.loadTarget) begin
      stateQ  <= SEED;
      targetQ <= targetIn;
    end else if (strobes.stepFwd) begin
      stateQ  <= fwdNext;
    end else if (strobes.stepRev) begin
      stateQ  <= revNext;
    end
  end

  assign state    = stateQ;
  assign atTarget = (stateQ == targetQ);

  // R6: the lock-up state is never entered
  a_r6_never_zero: assert property (@(posedge clk) disable iff (!rstN)
    stateQ != '0);

  // R2: a forward step moves each bit up one place
  a_r2_fwd_shift: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stepFwd |=> stateQ[TopIdx:1] == $past(stateQ[TopIdx-1:0]));

  // R3: a reverse step moves each bit down one place
  a_r3_rev_shift: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stepRev |=> stateQ[TopIdx-1:0] == $past(stateQ[TopIdx:1]));

  // R4: no strobe means the state holds
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.stepFwd || strobes.stepRev || strobes.loadTarget) |=> $stable(stateQ));

  // R7: a load restarts at the seed
  a_r7_load_restart: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadTarget |=> stateQ == SEED);

  // R8: the stored target is never zero
  a_r8_target_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    targetQ != '0);

endmodule

// File: rtl/lfsr_updown_counter.sv
module lfsr_updown_counter
  import lfsr_pkg::*;
#(
  parameter int unsigned WIDTH = DefaultWidth
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepEn,
  input  logic             stepDown,
  input  logic             loadStrobe,
  input  logic [WIDTH-1:0] loadValue,
  output logic [WIDTH-1:0] state,
  output logic             atTarget
);

  localparam int unsigned TapIdx = WIDTH - 2;
  localparam logic [WIDTH-1:0] Seed = {{(WIDTH-1){1'b0}}, 1'b1};

  lfsrStrobes_t strobes;

  lfsr_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .stepEn     (stepEn),
    .stepDown   (stepDown),
    .loadStrobe (loadStrobe),
    .strobes    (strobes)
  );

  lfsr_datapath #(
    .WIDTH   (WIDTH),
    .TAP_IDX (TapIdx),
    .SEED    (Seed)
  ) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .loadValue (loadValue),
    .state     (state),
    .atTarget  (atTarget)
  );

endmodule

// File: tb/lfsr_updown_counter_test.sv
`timescale 1ns/1ps
module lfsr_updown_counter_test;

  localparam int W = 15;
  localparam int PERIOD = 32767;
  localparam logic [W-1:0] SEED = 15'h0001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stepEn = 1'b0;
  logic stepDown = 1'b0;
  logic loadStrobe = 1'b0;
  logic [W-1:0] loadValue = '0;
  logic [W-1:0] state;
  logic atTarget;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;
  int unsigned lcg = 32'h1234_5678;

  always #2.5 clk = ~clk;

  lfsr_updown_counter uut (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .stepDown(stepDown),
    .loadStrobe(loadStrobe), .loadValue(loadValue),
    .state(state), .atTarget(atTarget)
  );

  // Reference step arithmetic, written from the requirements.
  function automatic logic [W-1:0] refFwd(input logic [W-1:0] q);
    return (q << 1) | {{(W-1){1'b0}}, q[14] ^ q[13]};
  endfunction
  function automatic logic [W-1:0] refRev(input logic [W-1:0] q);
    return (q >> 1) | {q[0] ^ q[14], {(W-1){1'b0}}};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic en, input logic down, input logic ld, input logic [W-1:0] val);
    @(negedge clk);
    stepEn = en; stepDown = down; loadStrobe = ld; loadValue = val;
    @(posedge clk);
    #1;
    stepEn = 1'b0; loadStrobe = 1'b0;
  endtask

  function automatic int unsigned nextRand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg >> 8;
  endfunction

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin : main
    logic [W-1:0] exp;
    logic [W-1:0] start;
    int earlyReturn;
    int zeroSeen;
    int mism;

    // R1: during reset and the first cycle after it
    #12;
    check(state == SEED, "R1 state in reset", state, SEED);
    check(atTarget == 1'b1, "R1 match in reset", atTarget, 1);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check(state == SEED, "R1 state after reset", state, SEED);

    // R4: hold with no enable
    cycle(0, 1, 0, '0);
    cycle(0, 0, 0, '0);
    check(state == SEED, "R4 hold", state, SEED);

    // R2, R5, R6: full forward period
    exp = SEED; earlyReturn = 0; zeroSeen = 0; mism = 0;
    for (int i = 1; i <= PERIOD; i++) begin
      cycle(1, 0, 0, '0);
      exp = refFwd(exp);
      if (state !== exp) mism++;
      if (state == '0) zeroSeen++;
      if (i < PERIOD && state == SEED) earlyReturn++;
    end
    check(mism == 0, "R2 forward sequence mismatches", mism, 0);
    check(zeroSeen == 0, "R6 zero states seen", zeroSeen, 0);
    check(earlyReturn == 0, "R5 early returns to seed", earlyReturn, 0);
    check(state == SEED, "R5 back at seed after period", state, SEED);

    // R3: random forward-then-reverse walks
    for (int t = 0; t < 8; t++) begin
      int n;
      n = 1 + int'(nextRand() % 200);
      start = state;
      for (int i = 0; i < n; i++) cycle(1, 0, 0, '0);
      exp = start; mism = 0;
      for (int i = 0; i < n; i++) begin
        exp = refFwd(exp);
      end
      for (int i = 0; i < n; i++) begin
        cycle(1, 1, 0, '0);
        exp = refRev(exp);
        if (state !== exp || state == '0) mism++;
      end
      check(mism == 0 && state == start, "R3 walk returns to start", state, start);
    end

    // R3: single reverse from seed then forward
    cycle(1, 0, 1, 15'h7ABC);
    cycle(1, 1, 0, '0);
    check(state == refRev(SEED), "R3 reverse from seed", state, refRev(SEED));
    cycle(1, 0, 0, '0);
    check(state == SEED, "R3 forward undoes reverse", state, SEED);

    // R7, R9: load a target 10 forward steps out, count to it
    exp = SEED;
    for (int i = 0; i < 10; i++) exp = refFwd(exp);
    cycle(1, 0, 1, exp);   // step requested with load: load wins
    check(state == SEED, "R7 load restarts at seed despite step", state, SEED);
    check(atTarget == 1'b0, "R9 no match at seed", atTarget, 0);
    mism = 0;
    for (int i = 1; i <= 10; i++) begin
      cycle(1, 0, 0, '0);
      if (atTarget !== (i == 10)) mism++;
    end
    check(mism == 0 && atTarget, "R9 match exactly at step 10", atTarget, 1);
    cycle(1, 0, 0, '0);
    check(atTarget == 1'b0, "R9 match drops after passing target", atTarget, 0);
    cycle(1, 1, 0, '0);
    check(atTarget == 1'b1, "R9 match reached in reverse", atTarget, 1);

    // R8: loading zero stores the seed as target
    cycle(1, 0, 0, '0);
    cycle(0, 0, 1, '0);
    check(state == SEED && atTarget == 1'b1, "R8 zero load gives seed target", {state, atTarget}, {SEED, 1'b1});
    cycle(1, 0, 0, '0);
    check(atTarget == 1'b0, "R8 seed target left after step", atTarget, 0);

    // R7: load during reverse step request
    cycle(1, 1, 1, 15'h0002);
    check(state == SEED, "R7 load beats reverse step", state, SEED);
    cycle(1, 0, 0, '0);
    check(atTarget == 1'b1 && state == 15'h0002, "R7 new target reached", state, 15'h0002);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule